// File: doc/BRIEF.md
# Segmented Fetch-Address Generator with Straight-Line Limit

This block supplies the instruction-fetch address of a small processor core. A 16-bit base register holds the target of the most recent control transfer, and a narrow offset counter counts fetches since then. The fetch address is their sum. Because the offset counter is short and cannot wrap, the core can never use its address logic to step through the whole memory. It can only advance a bounded distance past a branch target.

Each fetch-advance strobe moves the offset on by one. Any jump, call or return arrives on the branch strobe with its destination. That destination replaces the base, and the offset returns to zero. An advance that would take the offset to its limit does not overflow. Instead it raises a one-cycle reset request to the core and returns base and offset to zero. With the default limit of 127, at most 127 consecutive bytes run between branches.

All pins are plain control and status signals with no data stream, so no valid/ready handshake applies. Strobes are sampled on every rising clock edge and cannot be stalled.

Top module: `seg_pc`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and in the first cycle after it is released, `fetch_addr` is 0 and `core_rst_req` is 0.
- R2: `fetch_addr` equals the base register plus the zero-extended offset, taken modulo 2^16. For example, base 0xFFF0 with offset 40 gives 0x0018.
- R3: An advance with no branch, sampled while the offset is below `OFF_MAX-1`, raises the offset by one. `fetch_addr` is then one higher in the next cycle.
- R4: A branch sampled at a clock edge loads `br_dest` into the base and clears the offset. `fetch_addr` equals `br_dest` in the next cycle. A branch and an advance in the same cycle act as the branch alone.
- R5: The offset never reaches `OFF_MAX`. An advance with no branch, sampled while the offset equals `OFF_MAX-1`, drives `core_rst_req` to 1 and `fetch_addr` to 0 in the next cycle. With the defaults, 126 advances after a branch leave `core_rst_req` low, and the 127th raises it.
- R6: `core_rst_req` stays high for exactly one cycle. Advance and branch strobes sampled in that cycle are ignored, and `fetch_addr` is 0 in the cycle after it.
- R7: With neither strobe asserted (and no reset request pending), `fetch_addr` does not change.
- R8: A branch in the same cycle as a limit-reaching advance takes priority. No reset request is raised, and `fetch_addr` becomes `br_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_adv | input | 1 | One instruction byte fetched; step the offset |
| br_valid | input | 1 | Jump, call or return taken this cycle |
| br_dest | input | 16 | Destination of the control transfer |
| fetch_addr | output | 16 | Current fetch address (base + offset) |
| core_rst_req | output | 1 | One-cycle request to reset the processor |

## Verification
Every strobe sampled at a rising edge shows its result one cycle later. This covers the new address after an advance or branch, and the reset request after a limit-reaching advance. `fetch_addr` is a combinational sum of registers, so it needs no extra cycle. The bench drives strobes on the falling edge and keeps a behavioural model that takes the same strobes at the rising edge. The outputs are compared with the model at the next falling edge, half a cycle after the update they reflect. Targeted sequences then check the exact advance count that trips the limit, the squashed cycle that follows, and address wrap across 0xFFFF.

// File: rtl/seg_pc_pkg.sv
package seg_pc_pkg;

  // Per-cycle operation applied to base and offset registers
  typedef enum logic [2:0] {
    PC_HOLD   = 3'd0,  // nothing sampled
    PC_STEP   = 3'd1,  // offset + 1
    PC_LOAD   = 3'd2,  // new base, offset cleared
    PC_TRAP   = 3'd3,  // limit reached: clear both, raise request
    PC_SQUASH = 3'd4   // request cycle: clear both, ignore strobes
  } pc_op_e;

endpackage

// File: rtl/seg_pc_basereg.sv
module seg_pc_basereg
  import seg_pc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_op_e            op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] base_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      unique case (op)
        PC_LOAD:            base_q <= load_val;
        PC_TRAP, PC_SQUASH: base_q <= '0;
        default:            base_q <= base_q;
      endcase
    end
  end

endmodule

// File: rtl/seg_pc_offctr.sv
module seg_pc_offctr
  import seg_pc_pkg::*;
#(
  parameter int OFF_W   = 7,
  parameter int OFF_MAX = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pc_op_e           op,
  output logic [OFF_W-1:0] off_q,
  output logic             at_last
);

  localparam logic [OFF_W-1:0] LAST = OFF_W'(OFF_MAX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else begin
      unique case (op)
        PC_STEP:                     off_q <= off_q + 1'b1;
        PC_LOAD, PC_TRAP, PC_SQUASH: off_q <= '0;
        default:                     off_q <= off_q;
      endcase
    end
  end

  assign at_last = (off_q == LAST);

endmodule

// File: rtl/seg_pc_addgen.sv
module seg_pc_addgen #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] off_ext;

  generate
    if (OFF_W < ADDR_W) begin : g_pad
      localparam int PAD = ADDR_W - OFF_W;
      assign off_ext = {{PAD{1'b0}}, off};
    end else begin : g_trunc
      assign off_ext = off[ADDR_W-1:0];
    end
  endgenerate

  // Sum wraps modulo 2^ADDR_W
  assign addr = base + off_ext;

endmodule

// File: rtl/seg_pc.sv
module seg_pc
  import seg_pc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 7,
  parameter int OFF_MAX = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_adv,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_dest,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              core_rst_req
);

  pc_op_e            op;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic              at_last;
  logic              req_q;

  // Priority: pending request, branch, limit-reaching advance, advance
  always_comb begin
    if (req_q)                  op = PC_SQUASH;
    else if (br_valid)          op = PC_LOAD;
    else if (fetch_adv && at_last) op = PC_TRAP;
    else if (fetch_adv)         op = PC_STEP;
    else                        op = PC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= (op == PC_TRAP);
  end

  seg_pc_basereg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (br_dest),
    .base_q   (base_q)
  );

  seg_pc_offctr #(.OFF_W(OFF_W), .OFF_MAX(OFF_MAX)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .off_q   (off_q),
    .at_last (at_last)
  );

  seg_pc_addgen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
    .base (base_q),
    .off  (off_q),
    .addr (fetch_addr)
  );

  assign core_rst_req = req_q;

endmodule

// File: rtl/seg_pc_chk.sv
module seg_pc_chk #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 7,
  parameter int OFF_MAX = 127
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_adv,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_dest,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              core_rst_req,
  input logic [OFF_W-1:0]  off
);

  localparam logic [OFF_W-1:0] LAST = OFF_W'(OFF_MAX - 1);

  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !core_rst_req) |=> (fetch_addr == $past(br_dest))); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !br_valid && !core_rst_req && off != LAST)
      |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1))); // R3

  AST_LIMIT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !br_valid && !core_rst_req && off == LAST)
      |=> (core_rst_req && fetch_addr == '0)); // R5

  AST_OFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    off <= LAST); // R5

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |=> (!core_rst_req && fetch_addr == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_adv && !br_valid && !core_rst_req) |=> $stable(fetch_addr)); // R7

  AST_BRANCH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !core_rst_req) |=> !core_rst_req); // R8

endmodule

bind seg_pc seg_pc_chk #(
  .ADDR_W  (ADDR_W),
  .OFF_W   (OFF_W),
  .OFF_MAX (OFF_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_adv    (fetch_adv),
  .br_valid     (br_valid),
  .br_dest      (br_dest),
  .fetch_addr   (fetch_addr),
  .core_rst_req (core_rst_req),
  .off          (off_q)
);

// File: tb/seg_pc_bench.sv
module seg_pc_bench;

  localparam int OFF_MAX = 127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_adv = 1'b0;
  logic        br_valid = 1'b0;
  logic [15:0] br_dest = '0;
  logic [15:0] fetch_addr;
  logic        core_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  seg_pc u_seg_pc (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_adv    (fetch_adv),
    .br_valid     (br_valid),
    .br_dest      (br_dest),
    .fetch_addr   (fetch_addr),
    .core_rst_req (core_rst_req)
  );

  // Behavioural reference model
  int    m_seg = 0;
  int    m_off = 0;
  bit    m_req = 0;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_seg <= 0; m_off <= 0; m_req <= 0; m_tag <= "R1";
    end else if (m_req) begin
      m_seg <= 0; m_off <= 0; m_req <= 0; m_tag <= "R6";
    end else if (br_valid) begin
      m_seg <= int'(br_dest); m_off <= 0;
      m_tag <= (fetch_adv && m_off == OFF_MAX - 1) ? "R8" : "R4";
    end else if (fetch_adv) begin
      if (m_off == OFF_MAX - 1) begin
        m_seg <= 0; m_off <= 0; m_req <= 1; m_tag <= "R5";
      end else begin
        m_off <= m_off + 1; m_tag <= "R3";
      end
    end else begin
      m_tag <= "R7";
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    check(m_tag, int'(fetch_addr), (m_seg + m_off) & 16'hFFFF);
    check(m_tag, int'(core_rst_req), int'(m_req));
  endtask

  // Called just after a falling edge: drive, wait one cycle, compare
  task automatic step(input bit a, input bit b, input logic [15:0] d);
    fetch_adv = a; br_valid = b; br_dest = d;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", int'(fetch_addr), 0);
    check("R1", int'(core_rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();  // R1 first cycle after release

    // R4 then R3: branch and straight-line advances
    step(0, 1, 16'h1000);
    check("R4", int'(fetch_addr), 16'h1000);
    for (int i = 0; i < 10; i++) step(1, 0, '0);
    check("R3", int'(fetch_addr), 16'h100A);
    // R7: idle holds address
    for (int i = 0; i < 3; i++) step(0, 0, 16'hBEEF);
    check("R7", int'(fetch_addr), 16'h100A);

    // R2: wrap across 0xFFFF
    step(0, 1, 16'hFFF0);
    for (int i = 0; i < 40; i++) step(1, 0, '0);
    check("R2", int'(fetch_addr), 16'h0018);

    // R4: branch beats advance in the same cycle
    step(1, 1, 16'h2000);
    check("R4", int'(fetch_addr), 16'h2000);

    // R5: 126 advances stay legal, the 127th requests reset
    for (int i = 0; i < OFF_MAX - 1; i++) step(1, 0, '0);
    check("R5", int'(core_rst_req), 0);
    check("R5", int'(fetch_addr), 16'h2000 + OFF_MAX - 1);
    step(1, 0, '0);
    check("R5", int'(core_rst_req), 1);
    check("R5", int'(fetch_addr), 0);
    // R6: strobes during the request cycle are ignored
    step(1, 1, 16'h5555);
    check("R6", int'(core_rst_req), 0);
    check("R6", int'(fetch_addr), 0);
    step(1, 0, '0);
    check("R6", int'(fetch_addr), 1);

    // R8: branch coincides with the limit-reaching advance
    step(0, 1, 16'h3000);
    for (int i = 0; i < OFF_MAX - 1; i++) step(1, 0, '0);
    step(1, 1, 16'h4000);
    check("R8", int'(core_rst_req), 0);
    check("R8", int'(fetch_addr), 16'h4000);

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, ($urandom % 150) == 0, 16'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule